// File: doc/BRIEF.md
# Transmit Line Scanner

This block picks which line of a multi-line serial transmitter is served next. It steps a pointer round-robin over the transmit lines, one line per clock. The pointer stops on the first line whose transmit holding buffer is empty and whose per-line enable is set. It then shows a ready flag and the line number, and it can raise an interrupt request. Scanning runs only while the master scan enable is high.

Software answers the ready flag by writing one character. The block hands that character to the holding buffer of the reported line, and the scan then resumes from the following line number. Because of this, a line that stays ready cannot shut the others out.

The block also owns the per-line transmit control register. This register has two halves: a byte of per-line transmit enables and a byte of per-line data-terminal-ready outputs. Master clear wipes the enables and the scan state, but it leaves the data-terminal-ready half unchanged. Only the chip reset clears that half.

Top module: `tx_line_scanner`

## Requirements
- R1: After `rst_n` is low, `tx_rdy`, `tx_irq`, `tx_line`, `tcr_en` and `dtr` are all zero.
- R2: While scanning is enabled and the line under the pointer does not qualify, `tx_line` advances by one each clock and wraps from NUM_LINES-1 to 0. A line qualifies when both its `tcr_en` bit and its `line_empty` bit are 1.
- R3: When the pointer reaches a qualifying line, `tx_rdy` rises one clock later. `tx_line` then holds that line number for as long as the line still qualifies and no character is accepted. A line whose `line_empty` bit is 0 is skipped.
- R4: `tx_irq` is high exactly when `tx_rdy` and `tx_ie` are both high.
- R5: When `scan_en` goes low, `tx_rdy` and `tx_irq` drop in the same cycle, and the pointer stays where it is. When `scan_en` is high again, scanning resumes from that pointer.
- R6: `tdr_ready` equals `tx_rdy`. An accepted character (`tdr_valid` and `tdr_ready` both high) shows in the same cycle on `load_valid`, `load_line` and `load_data`. On the next clock `tx_rdy` is low and `tx_line` is the following line number. A write offered while `tdr_ready` is low produces no load and does not move the pointer.
- R7: If the enable bit of the reported line is cleared, `tx_rdy` drops once the new enable takes effect. One clock later the scan moves on to the next line.
- R8: A one-cycle `mclr` clears `tcr_en`, the ready state and the pointer (to 0), and leaves `dtr` unchanged.
- R9: `en_wr` loads `tcr_en` from `en_wdata`, and `dtr_wr` loads `dtr` from `dtr_wdata`, on the next clock. Each write leaves the other half unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, clears everything |
| mclr | input | 1 | Master clear, keeps the data-terminal-ready byte |
| scan_en | input | 1 | Master scan enable |
| tx_ie | input | 1 | Transmit interrupt enable |
| en_wr | input | 1 | Write strobe for the enable byte |
| en_wdata | input | NUM_LINES | New per-line transmit enables |
| dtr_wr | input | 1 | Write strobe for the data-terminal-ready byte |
| dtr_wdata | input | NUM_LINES | New per-line data-terminal-ready values |
| line_empty | input | NUM_LINES | Per-line holding-buffer-empty status |
| tdr_valid | input | 1 | Character write offered |
| tdr_data | input | DATA_W | Character to send |
| tdr_ready | output | 1 | Character accepted this cycle if valid |
| load_valid | output | 1 | Load strobe to the holding buffer of `load_line` |
| load_line | output | LINE_W | Line being loaded |
| load_data | output | DATA_W | Character being loaded |
| tx_rdy | output | 1 | A line is ready for a character |
| tx_line | output | LINE_W | Scan pointer; the ready line when `tx_rdy` is high |
| tx_irq | output | 1 | Transmit interrupt request |
| tcr_en | output | NUM_LINES | Per-line transmit enables |
| dtr | output | NUM_LINES | Per-line data-terminal-ready outputs |

## Verification
The hardest case to set up is fairness. With every line enabled and every buffer empty, the pointer never has a reason to move. The only thing that advances it is an accepted character, and it must then go to the next line number and not back to the same line. The bench holds all lines qualifying and accepts a character. It then checks that the next ready line is the following number, even though the line just served still qualifies. A second case clears the enable of the line currently being reported, while it is ready. The bench watches ready drop and the pointer leave that line.

// File: rtl/tx_scan_pkg.sv
package tx_scan_pkg;
  typedef enum logic {ST_SEEK = 1'b0, ST_HOLD = 1'b1} scan_state_t;

  function automatic int unsigned wrap_next(int unsigned cur, int unsigned n);
    return (cur >= n - 1) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/txs_ctrl_reg.sv
module txs_ctrl_reg #(
  parameter int NUM_LINES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mclr,
  input  logic                 en_wr,
  input  logic [NUM_LINES-1:0] en_wdata,
  input  logic                 dtr_wr,
  input  logic [NUM_LINES-1:0] dtr_wdata,
  output logic [NUM_LINES-1:0] en_q,
  output logic [NUM_LINES-1:0] dtr_q
);
  // enable byte: cleared by reset and by master clear
  always_ff @(posedge clk) begin
    if (!rst_n || mclr) en_q <= '0;
    else if (en_wr)     en_q <= en_wdata;
  end

  // modem-control byte: only chip reset clears it
  always_ff @(posedge clk) begin
    if (!rst_n)      dtr_q <= '0;
    else if (dtr_wr) dtr_q <= dtr_wdata;
  end
endmodule

// File: rtl/txs_scanner.sv
module txs_scanner
  import tx_scan_pkg::*;
#(
  parameter int NUM_LINES = 4,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mclr,
  input  logic                 scan_en,
  input  logic [NUM_LINES-1:0] qual_vec,
  input  logic                 take,
  output logic [LINE_W-1:0]    ptr,
  output logic                 rdy
);
  localparam logic [LINE_W-1:0] LAST = LINE_W'(NUM_LINES - 1);

  scan_state_t      state;
  logic             qual;
  logic [LINE_W-1:0] ptr_nxt;

  assign qual    = scan_en & qual_vec[ptr];
  assign rdy     = (state == ST_HOLD) & qual;
  assign ptr_nxt = (ptr == LAST) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || mclr) begin
      state <= ST_SEEK;
      ptr   <= '0;
    end else if (!scan_en) begin
      state <= ST_SEEK;
    end else if (state == ST_HOLD) begin
      if (!qual || take) begin
        state <= ST_SEEK;
        ptr   <= ptr_nxt;
      end
    end else if (qual) begin
      state <= ST_HOLD;
    end else begin
      ptr <= ptr_nxt;
    end
  end
endmodule

// File: rtl/tx_line_scanner.sv
module tx_line_scanner #(
  parameter int NUM_LINES = 4,
  parameter int DATA_W    = 8,
  localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mclr,
  input  logic                 scan_en,
  input  logic                 tx_ie,
  input  logic                 en_wr,
  input  logic [NUM_LINES-1:0] en_wdata,
  input  logic                 dtr_wr,
  input  logic [NUM_LINES-1:0] dtr_wdata,
  input  logic [NUM_LINES-1:0] line_empty,
  input  logic                 tdr_valid,
  input  logic [DATA_W-1:0]    tdr_data,
  output logic                 tdr_ready,
  output logic                 load_valid,
  output logic [LINE_W-1:0]    load_line,
  output logic [DATA_W-1:0]    load_data,
  output logic                 tx_rdy,
  output logic [LINE_W-1:0]    tx_line,
  output logic                 tx_irq,
  output logic [NUM_LINES-1:0] tcr_en,
  output logic [NUM_LINES-1:0] dtr
);
  logic [NUM_LINES-1:0] qual_vec;
  logic                 take;

  txs_ctrl_reg #(.NUM_LINES(NUM_LINES)) u_tcr (
    .clk(clk), .rst_n(rst_n), .mclr(mclr),
    .en_wr(en_wr), .en_wdata(en_wdata),
    .dtr_wr(dtr_wr), .dtr_wdata(dtr_wdata),
    .en_q(tcr_en), .dtr_q(dtr)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_qual
    assign qual_vec[i] = tcr_en[i] & line_empty[i];
  end

  txs_scanner #(.NUM_LINES(NUM_LINES)) u_scan (
    .clk(clk), .rst_n(rst_n), .mclr(mclr), .scan_en(scan_en),
    .qual_vec(qual_vec), .take(take), .ptr(tx_line), .rdy(tx_rdy)
  );

  assign tdr_ready  = tx_rdy;
  assign take       = tdr_valid & tx_rdy;
  assign load_valid = take;
  assign load_line  = tx_line;
  assign load_data  = tdr_data;
  assign tx_irq     = tx_rdy & tx_ie;
endmodule

// File: rtl/tx_line_scanner_chk.sv
module tx_line_scanner_chk
  import tx_scan_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int LINE_W = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 mclr,
  input logic                 scan_en,
  input logic                 dtr_wr,
  input logic [NUM_LINES-1:0] line_empty,
  input logic                 load_valid,
  input logic                 tx_rdy,
  input logic [LINE_W-1:0]    tx_line,
  input logic [NUM_LINES-1:0] tcr_en,
  input logic [NUM_LINES-1:0] dtr
);
  assert_load_drops_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid && !mclr |=> !tx_rdy);

  assert_load_advances_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid && !mclr |=> int'(tx_line) == wrap_next(int'($past(tx_line)), NUM_LINES));

  assert_skip_advances_R2: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en && !mclr && !(tcr_en[tx_line] && line_empty[tx_line])
    |=> int'(tx_line) == wrap_next(int'($past(tx_line)), NUM_LINES));

  assert_pause_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en && !mclr |=> $stable(tx_line) && !tx_rdy);

  assert_mclr_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> tcr_en == '0 && tx_line == '0 && !tx_rdy);

  assert_mclr_keeps_dtr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mclr && !dtr_wr |=> $stable(dtr));
endmodule

bind tx_line_scanner tx_line_scanner_chk #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mclr(mclr), .scan_en(scan_en), .dtr_wr(dtr_wr),
  .line_empty(line_empty), .load_valid(load_valid), .tx_rdy(tx_rdy),
  .tx_line(tx_line), .tcr_en(tcr_en), .dtr(dtr)
);

// File: tb/tx_line_scanner_test.sv
module tx_line_scanner_test;
  localparam int N = 4;
  localparam int DW = 8;
  localparam int LW = 2;

  logic clk = 1'b0;
  logic rst_n, mclr, scan_en, tx_ie, en_wr, dtr_wr, tdr_valid;
  logic [N-1:0] en_wdata, dtr_wdata, line_empty;
  logic [DW-1:0] tdr_data;
  logic tdr_ready, load_valid, tx_rdy, tx_irq;
  logic [LW-1:0] load_line, tx_line;
  logic [DW-1:0] load_data;
  logic [N-1:0] tcr_en, dtr;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tx_line_scanner #(.NUM_LINES(N), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .mclr(mclr), .scan_en(scan_en), .tx_ie(tx_ie),
    .en_wr(en_wr), .en_wdata(en_wdata), .dtr_wr(dtr_wr), .dtr_wdata(dtr_wdata),
    .line_empty(line_empty), .tdr_valid(tdr_valid), .tdr_data(tdr_data),
    .tdr_ready(tdr_ready), .load_valid(load_valid), .load_line(load_line),
    .load_data(load_data), .tx_rdy(tx_rdy), .tx_line(tx_line), .tx_irq(tx_irq),
    .tcr_en(tcr_en), .dtr(dtr)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // step one rising edge, land just after the next falling edge
  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; mclr = 0; scan_en = 0; tx_ie = 0; en_wr = 0; dtr_wr = 0;
    tdr_valid = 0; en_wdata = '0; dtr_wdata = '0; line_empty = '1; tdr_data = '0;
    step(2);
    rst_n = 1;
  endtask

  task automatic set_en(logic [N-1:0] v);
    en_wr = 1; en_wdata = v;
    step();
    en_wr = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "tx_rdy", tx_rdy, 0);
    chk("R1", "tx_irq", tx_irq, 0);
    chk("R1", "tx_line", tx_line, 0);
    chk("R1", "tcr_en", tcr_en, 0);
    chk("R1", "dtr", dtr, 0);
  endtask

  task automatic t_scan_wrap();
    do_reset();
    scan_en = 1;
    for (int k = 1; k <= 5; k++) begin
      step();
      chk("R2", "tx_line advance", tx_line, k % N);
      chk("R2", "tx_rdy idle", tx_rdy, 0);
    end
  endtask

  task automatic t_stop_skip();
    do_reset();
    tx_ie = 1;
    line_empty = 4'b1000;
    set_en(4'b1111);
    chk("R9", "tcr_en write", tcr_en, 15);
    scan_en = 1;
    step(3);
    chk("R3", "line before stop", tx_line, 3);
    chk("R3", "not yet ready", tx_rdy, 0);
    step();
    chk("R3", "ready", tx_rdy, 1);
    chk("R3", "ready line", tx_line, 3);
    chk("R4", "irq with ie", tx_irq, 1);
    step(3);
    chk("R3", "holds line", tx_line, 3);
    chk("R3", "holds ready", tx_rdy, 1);
    tx_ie = 0; #1;
    chk("R4", "irq without ie", tx_irq, 0);
  endtask

  task automatic t_load_fair();
    do_reset();
    set_en(4'b1111);
    scan_en = 1;
    tdr_valid = 1; tdr_data = 8'h5a; #1;
    chk("R6", "write ignored when not ready", load_valid, 0);
    chk("R6", "tdr_ready low", tdr_ready, 0);
    tdr_valid = 0;
    step();
    chk("R6", "ignored write kept pointer", tx_line, 0);
    chk("R3", "ready at 0", tx_rdy, 1);
    tdr_valid = 1; tdr_data = 8'hA5; #1;
    chk("R6", "tdr_ready", tdr_ready, 1);
    chk("R6", "load_valid", load_valid, 1);
    chk("R6", "load_line", load_line, 0);
    chk("R6", "load_data", load_data, 8'hA5);
    step();
    tdr_valid = 0;
    chk("R6", "ready drops after load", tx_rdy, 0);
    chk("R6", "next line after load", tx_line, 1);
    step();
    chk("R6", "line 1 ready next", tx_rdy, 1);
    chk("R6", "line 1 reported", tx_line, 1);
  endtask

  task automatic t_pause();
    do_reset();
    tx_ie = 1;
    set_en(4'b0100);
    scan_en = 1;
    step(3);
    chk("R3", "ready at 2", tx_rdy, 1);
    scan_en = 0; #1;
    chk("R5", "ready drops at once", tx_rdy, 0);
    chk("R5", "irq drops at once", tx_irq, 0);
    step(3);
    chk("R5", "pointer held", tx_line, 2);
    chk("R5", "still not ready", tx_rdy, 0);
    scan_en = 1;
    step();
    chk("R5", "ready again", tx_rdy, 1);
    chk("R5", "same line", tx_line, 2);
  endtask

  task automatic t_en_clear();
    do_reset();
    set_en(4'b0101);
    scan_en = 1;
    step();
    chk("R3", "ready at 0", tx_rdy, 1);
    set_en(4'b0100);
    chk("R7", "ready dropped", tx_rdy, 0);
    chk("R7", "line still 0", tx_line, 0);
    step();
    chk("R7", "scan resumed", tx_line, 1);
    step(2);
    chk("R7", "next enabled line ready", tx_rdy, 1);
    chk("R7", "line 2", tx_line, 2);
  endtask

  task automatic t_mclr();
    do_reset();
    dtr_wr = 1; dtr_wdata = 4'b1010;
    step();
    dtr_wr = 0;
    chk("R9", "dtr write", dtr, 10);
    chk("R9", "en untouched by dtr write", tcr_en, 0);
    set_en(4'b1000);
    chk("R9", "dtr untouched by en write", dtr, 10);
    scan_en = 1;
    step(4);
    chk("R3", "ready at 3", tx_rdy, 1);
    mclr = 1;
    step();
    mclr = 0;
    chk("R8", "en cleared", tcr_en, 0);
    chk("R8", "dtr kept", dtr, 10);
    chk("R8", "line to 0", tx_line, 0);
    chk("R8", "ready cleared", tx_rdy, 0);
    rst_n = 0;
    step();
    rst_n = 1;
    chk("R1", "reset clears dtr", dtr, 0);
  endtask

  initial begin
    t_reset();
    t_scan_wrap();
    t_stop_skip();
    t_load_fair();
    t_pause();
    t_en_clear();
    t_mclr();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule